// File: doc/BRIEF.md
# Vertical Timing Phase Interrupt Generator

This block steps a display frame through its four vertical phases, one line at a time. A strobe that marks the end of each display line advances a line counter. When the counter reaches the programmed length of the current phase, the block moves on to the next phase. The order is vertical sync, back porch, active video, front porch, and then back to sync. The block drives a vertical sync output and an active-line flag. It also reports the current phase as a two-bit code.

Software picks one phase boundary with a two-bit select field. Entering that phase raises a one-cycle event. The event sets a sticky raw-status bit. That bit feeds the interrupt output through a mask-enable bit, and a write-one-to-clear pulse drops it. The select and mask registers have simple write strobes. Any bus adaptor can drive them.

While the timing enable is low, the block stays at line 0 of the sync phase. It starts counting again from there once the enable returns.

Top module: `vphase_irq_gen`

## Requirements
- R1: After reset, `phase_o` is 0 (sync), `vsync_o` is 1, `active_line_o` is 0, and `irq_evt_o`, `irq_raw_o` and `irq_o` are 0. The select field resets to 2'b00, so the first boundary into sync raises an event. The mask resets to 0, so `irq_o` stays low even when the raw bit is set.
- R2: `phase_o` encodes sync=0, back porch=1, active video=2 and front porch=3. With the enable high, phases follow in the order 0,1,2,3,0 and no code is skipped.
- R3: A phase whose length input is N (N>=1) lasts exactly N `line_done` strobes. A length of 0 acts as 1. The phase register changes on the clock edge that samples the last strobe.
- R4: `vsync_o` is high exactly while `phase_o` is 0. `active_line_o` is high exactly while `phase_o` is 2.
- R5: The select codes 2'b00, 2'b01, 2'b10 and 2'b11 choose the starts of sync, back porch, active video and front porch. `irq_evt_o` is high for one cycle: the first cycle in which `phase_o` shows the chosen phase after a boundary.
- R6: `irq_raw_o` sets on the same edge that raises `irq_evt_o`. It stays set until an `irq_clear` pulse. If an event and a clear fall on the same edge, the bit stays set.
- R7: `irq_o` equals `irq_raw_o` AND the mask bit. The mask bit is written from `mask_wdata` when `mask_we` is high.
- R8: A select write applies from the next phase boundary on. A write on the same cycle as a boundary takes effect only from the following boundary. A boundary already passed in the frame never fires afterwards.
- R9: While `timing_en` is low, the block goes to phase 0, line 0, on the next edge and ignores `line_done`. This forced return is not a boundary and raises no event. The raw bit keeps its value.
- R10: After `timing_en` rises, counting restarts from line 0 of the sync phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| timing_en | input | 1 | Timing enable; low holds phase 0, line 0 |
| line_done | input | 1 | One-cycle strobe at the end of each display line |
| len_sync | input | LINE_W | Sync phase length in lines |
| len_back | input | LINE_W | Back porch length in lines |
| len_active | input | LINE_W | Active video length in lines |
| len_front | input | LINE_W | Front porch length in lines |
| sel_we | input | 1 | Write strobe for the phase select field |
| sel_wdata | input | 2 | New phase select code |
| mask_we | input | 1 | Write strobe for the mask bit |
| mask_wdata | input | 1 | New mask bit |
| irq_clear | input | 1 | Write-one-to-clear pulse for the raw status |
| phase_o | output | 2 | Current phase code |
| vsync_o | output | 1 | Vertical sync, high in phase 0 |
| active_line_o | output | 1 | High in the active video phase |
| irq_evt_o | output | 1 | One-cycle phase-start event |
| irq_raw_o | output | 1 | Sticky raw status |
| irq_o | output | 1 | Masked interrupt |

## Verification
The hardest situation to reach from the ports is a select write that lands during a frame. There are two cases. In one, the write comes after the newly chosen boundary has already passed, so the boundary must stay silent until the next frame. In the other, the write lands on the very cycle a boundary is taken, so the old code must still decide that boundary.

The bench reaches both cases by counting `line_done` strobes against small, known phase lengths. It places the write on a chosen strobe, either alone or in the same cycle as that strobe. A second hard case is a clear that collides with a firing boundary. The bench reaches it the same way.

The rest of the stimulus is a sweep over every select code and several length sets, including a zero length. The expected phase and event positions come from cumulative sums of the lengths.

// File: rtl/vph_pkg.sv
// Package: shared phase type and sequencing helper for the vertical phase
// interrupt generator. Assumes a frame has exactly four phases.
package vph_pkg;

    typedef enum logic [1:0] {
        PH_SYNC   = 2'd0,
        PH_BACK   = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_FRONT  = 2'd3
    } vph_phase_e;

    // Successor of a phase in frame order; front porch wraps to sync.
    function automatic vph_phase_e vph_next(input vph_phase_e ph);
        case (ph)
            PH_SYNC:   return PH_BACK;
            PH_BACK:   return PH_ACTIVE;
            PH_ACTIVE: return PH_FRONT;
            default:   return PH_SYNC;
        endcase
    endfunction

endpackage

// File: rtl/vph_line_seq.sv
// Module: line counter and phase sequencer.
// Counts line_done strobes in the current phase and moves to the next phase
// after the programmed number of lines. A zero length behaves as one line.
// Assumes the length inputs are stable while the phase they describe runs.
module vph_line_seq
    import vph_pkg::*;
#(
    parameter int LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              timing_en,
    input  logic              line_done,
    input  logic [LINE_W-1:0] len_sync,
    input  logic [LINE_W-1:0] len_back,
    input  logic [LINE_W-1:0] len_active,
    input  logic [LINE_W-1:0] len_front,
    output vph_phase_e        phase_q,
    output logic [LINE_W-1:0] line_q,
    output logic              boundary,
    output vph_phase_e        phase_next
);

    localparam int CMP_W = LINE_W + 1;

    logic [LINE_W-1:0] cur_len;
    logic              last_line;

    // Pick the length of the running phase and decide if this is its last line.
    always_comb begin
        case (phase_q)
            PH_SYNC:   cur_len = len_sync;
            PH_BACK:   cur_len = len_back;
            PH_ACTIVE: cur_len = len_active;
            default:   cur_len = len_front;
        endcase
        last_line  = ({1'b0, line_q} + CMP_W'(1)) >= {1'b0, cur_len};
        phase_next = vph_next(phase_q);
        boundary   = timing_en && line_done && last_line;
    end

    // Advance the line count and phase; hold at sync line 0 while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !timing_en) begin
            phase_q <= PH_SYNC;
            line_q  <= '0;
        end else if (line_done) begin
            if (last_line) begin
                phase_q <= phase_next;
                line_q  <= '0;
            end else begin
                line_q  <= line_q + LINE_W'(1);
            end
        end
    end

endmodule

// File: rtl/vph_cfg_regs.sv
// Module: software-written configuration fields, the phase select code and
// the interrupt mask bit. Each field has its own write strobe.
// Assumes the strobes come from a bus adaptor outside this block.
module vph_cfg_regs
    import vph_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_we,
    input  logic [1:0] sel_wdata,
    input  logic       mask_we,
    input  logic       mask_wdata,
    output vph_phase_e sel_q,
    output logic       mask_q
);

    // Hold the select code and mask; both reset to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= PH_SYNC;
            mask_q <= 1'b0;
        end else begin
            if (sel_we)  sel_q  <= vph_phase_e'(sel_wdata);
            if (mask_we) mask_q <= mask_wdata;
        end
    end

endmodule

// File: rtl/vph_irq_status.sv
// Module: phase-start event, sticky raw status and masked interrupt.
// The boundary is compared against the select value present on that cycle,
// so a write lands from the next boundary and nothing fires retroactively.
// A set wins over a clear on the same edge.
module vph_irq_status
    import vph_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       boundary,
    input  vph_phase_e phase_next,
    input  vph_phase_e sel_q,
    input  logic       mask_q,
    input  logic       irq_clear,
    output logic       evt_q,
    output logic       raw_q,
    output logic       irq
);

    logic fire;

    // A boundary into the selected phase is an event.
    always_comb begin
        fire = boundary && (phase_next == sel_q);
    end

    // Register the event pulse and keep the sticky raw bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q <= 1'b0;
            raw_q <= 1'b0;
        end else begin
            evt_q <= fire;
            raw_q <= fire || (raw_q && !irq_clear);
        end
    end

    // Gate the raw bit with the mask.
    always_comb begin
        irq = raw_q && mask_q;
    end

endmodule

// File: rtl/vphase_irq_gen.sv
// Module: top of the vertical timing phase interrupt generator.
// Joins the sequencer, configuration fields and interrupt status, and
// decodes vertical sync and active-line flags from the phase.
module vphase_irq_gen
    import vph_pkg::*;
#(
    parameter int LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              timing_en,
    input  logic              line_done,
    input  logic [LINE_W-1:0] len_sync,
    input  logic [LINE_W-1:0] len_back,
    input  logic [LINE_W-1:0] len_active,
    input  logic [LINE_W-1:0] len_front,
    input  logic              sel_we,
    input  logic [1:0]        sel_wdata,
    input  logic              mask_we,
    input  logic              mask_wdata,
    input  logic              irq_clear,
    output logic [1:0]        phase_o,
    output logic              vsync_o,
    output logic              active_line_o,
    output logic              irq_evt_o,
    output logic              irq_raw_o,
    output logic              irq_o
);

    vph_phase_e        phase_q;
    vph_phase_e        phase_next;
    vph_phase_e        sel_q;
    logic [LINE_W-1:0] line_q;
    logic              boundary;
    logic              mask_q;

    vph_line_seq #(.LINE_W(LINE_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .timing_en  (timing_en),
        .line_done  (line_done),
        .len_sync   (len_sync),
        .len_back   (len_back),
        .len_active (len_active),
        .len_front  (len_front),
        .phase_q    (phase_q),
        .line_q     (line_q),
        .boundary   (boundary),
        .phase_next (phase_next)
    );

    vph_cfg_regs u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_we     (sel_we),
        .sel_wdata  (sel_wdata),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata),
        .sel_q      (sel_q),
        .mask_q     (mask_q)
    );

    vph_irq_status u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .boundary   (boundary),
        .phase_next (phase_next),
        .sel_q      (sel_q),
        .mask_q     (mask_q),
        .irq_clear  (irq_clear),
        .evt_q      (irq_evt_o),
        .raw_q      (irq_raw_o),
        .irq        (irq_o)
    );

    // Decode the phase outputs.
    always_comb begin
        phase_o       = phase_q;
        vsync_o       = (phase_q == PH_SYNC);
        active_line_o = (phase_q == PH_ACTIVE);
    end

endmodule

// File: rtl/vph_irq_checker.sv
// Module: property checker for vphase_irq_gen, bound to every instance.
// Observes ports and a few internal registers. Drives nothing.
module vph_irq_checker #(
    parameter int LINE_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              timing_en,
    input logic              irq_clear,
    input logic [1:0]        phase_o,
    input logic [LINE_W-1:0] line_q,
    input logic [1:0]        sel_q,
    input logic              vsync_o,
    input logic              active_line_o,
    input logic              irq_evt_o,
    input logic              irq_raw_o,
    input logic              irq_o
);

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        timing_en |=> (phase_o == $past(phase_o) || phase_o == $past(phase_o) + 2'd1)); // R2

    AST_ACTIVE_FROM_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active_line_o) |-> $past(phase_o) == 2'd1); // R4

    AST_VSYNC_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vsync_o) |-> ($past(phase_o) == 2'd3 || !$past(timing_en))); // R4

    AST_EVT_AT_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        irq_evt_o |-> (phase_o == $past(sel_q) && phase_o != $past(phase_o))); // R5

    AST_EVT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_evt_o |=> !irq_evt_o); // R5

    AST_RAW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_raw_o && !irq_clear) |=> irq_raw_o); // R6

    AST_RAW_SET_BY_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_raw_o) |-> irq_evt_o); // R6

    AST_IRQ_NEEDS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> irq_raw_o); // R7

    AST_DISABLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !timing_en |=> (phase_o == 2'd0 && line_q == '0 && !irq_evt_o)); // R9

endmodule

bind vphase_irq_gen vph_irq_checker #(.LINE_W(LINE_W)) u_chk (.*);

// File: tb/tb_vphase_irq_gen.sv
module tb_vphase_irq_gen;

    localparam int LW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          timing_en = 1'b0;
    logic          line_done = 1'b0;
    logic [LW-1:0] len_sync = '0, len_back = '0, len_active = '0, len_front = '0;
    logic          sel_we = 1'b0;
    logic [1:0]    sel_wdata = '0;
    logic          mask_we = 1'b0;
    logic          mask_wdata = 1'b0;
    logic          irq_clear = 1'b0;
    logic [1:0]    phase_o;
    logic          vsync_o, active_line_o, irq_evt_o, irq_raw_o, irq_o;

    int checks = 0;
    int errors = 0;

    vphase_irq_gen #(.LINE_W(LW)) dut (
        .clk(clk), .rst_n(rst_n), .timing_en(timing_en), .line_done(line_done),
        .len_sync(len_sync), .len_back(len_back), .len_active(len_active),
        .len_front(len_front), .sel_we(sel_we), .sel_wdata(sel_wdata),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .irq_clear(irq_clear),
        .phase_o(phase_o), .vsync_o(vsync_o), .active_line_o(active_line_o),
        .irq_evt_o(irq_evt_o), .irq_raw_o(irq_raw_o), .irq_o(irq_o)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One line_done strobe, optionally with clear or select write; samples one cycle after the edge.
    task automatic step(input bit clr, input bit we, input logic [1:0] wd);
        @(negedge clk);
        line_done = 1'b1; irq_clear = clr; sel_we = we; sel_wdata = wd;
        @(negedge clk);
        line_done = 1'b0; irq_clear = 1'b0; sel_we = 1'b0;
    endtask

    task automatic write_cfg(input logic [1:0] s, input bit m);
        @(negedge clk);
        sel_we = 1'b1; sel_wdata = s; mask_we = 1'b1; mask_wdata = m;
        @(negedge clk);
        sel_we = 1'b0; mask_we = 1'b0;
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        irq_clear = 1'b1;
        @(negedge clk);
        irq_clear = 1'b0;
    endtask

    task automatic set_len(input int a, input int b, input int c, input int d);
        len_sync = LW'(a); len_back = LW'(b); len_active = LW'(c); len_front = LW'(d);
    endtask

    task automatic restart();
        @(negedge clk);
        timing_en = 1'b0;
        @(negedge clk);
        timing_en = 1'b1;
    endtask

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    // Sweep: one configuration, two frames plus one line, all outputs checked per line.
    task automatic run_cfg(input int a, input int b, input int c, input int d,
                           input int sel, input bit msk);
        int c1, c2, c3, total, pos, ph, st;
        bit raw_e, evt_e;
        set_len(a, b, c, d);
        @(negedge clk); timing_en = 1'b0;
        write_cfg(2'(sel), msk);
        pulse_clear();
        @(negedge clk); timing_en = 1'b1;
        check("R10 restart phase", int'(phase_o), 0);
        c1 = eff(a); c2 = c1 + eff(b); c3 = c2 + eff(c); total = c3 + eff(d);
        st = (sel == 0) ? 0 : (sel == 1) ? c1 : (sel == 2) ? c2 : c3;
        raw_e = 1'b0;
        for (int k = 1; k <= 2 * total + 1; k++) begin
            step(1'b0, 1'b0, 2'd0);
            pos = k % total;
            ph = (pos < c1) ? 0 : (pos < c2) ? 1 : (pos < c3) ? 2 : 3;
            evt_e = (pos == st);
            raw_e = raw_e | evt_e;
            check("R2/R3 phase", int'(phase_o), ph);
            check("R4 vsync", int'(vsync_o), int'(ph == 0));
            check("R4 active", int'(active_line_o), int'(ph == 2));
            check("R5 event", int'(irq_evt_o), int'(evt_e));
            check("R6 raw", int'(irq_raw_o), int'(raw_e));
            check("R7 irq", int'(irq_o), int'(raw_e && msk));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 phase", int'(phase_o), 0);
        check("R1 vsync", int'(vsync_o), 1);
        check("R1 active", int'(active_line_o), 0);
        check("R1 evt", int'(irq_evt_o), 0);
        check("R1 raw", int'(irq_raw_o), 0);
        check("R1 irq", int'(irq_o), 0);
        // R1 select reset 00 and mask reset 0: wrap into sync fires, irq stays low
        set_len(1, 1, 1, 1);
        @(negedge clk); timing_en = 1'b1;
        step(1'b0, 1'b0, 2'd0); step(1'b0, 1'b0, 2'd0); step(1'b0, 1'b0, 2'd0);
        check("R1 no evt before wrap", int'(irq_evt_o), 0);
        step(1'b0, 1'b0, 2'd0);
        check("R1 default select evt", int'(irq_evt_o), 1);
        check("R1 raw set", int'(irq_raw_o), 1);
        check("R1 mask default blocks irq", int'(irq_o), 0);

        // R9 line_done ignored while disabled
        @(negedge clk); timing_en = 1'b0;
        step(1'b0, 1'b0, 2'd0); step(1'b0, 1'b0, 2'd0);
        check("R9 held phase", int'(phase_o), 0);
        check("R9 raw kept", int'(irq_raw_o), 1);

        // R9/R10 disable mid-frame: no event on forced return, restart from line 0
        set_len(2, 2, 2, 2);
        write_cfg(2'd0, 1'b1);
        pulse_clear();
        @(negedge clk); timing_en = 1'b1;
        step(1'b0, 1'b0, 2'd0); step(1'b0, 1'b0, 2'd0); step(1'b0, 1'b0, 2'd0);
        check("R3 in back porch", int'(phase_o), 1);
        @(negedge clk); timing_en = 1'b0;
        @(negedge clk);
        check("R9 forced to sync", int'(phase_o), 0);
        check("R9 no event on forced return", int'(irq_evt_o), 0);
        check("R9 raw untouched", int'(irq_raw_o), 0);
        timing_en = 1'b1;
        step(1'b0, 1'b0, 2'd0);
        check("R10 still sync after one line", int'(phase_o), 0);
        step(1'b0, 1'b0, 2'd0);
        check("R10 back after two lines", int'(phase_o), 1);

        // R6 clear colliding with a firing boundary
        set_len(1, 1, 1, 1);
        write_cfg(2'd1, 1'b1);
        restart();
        pulse_clear();
        step(1'b0, 1'b0, 2'd0);
        check("R6 evt into back", int'(irq_evt_o), 1);
        step(1'b0, 1'b0, 2'd0); step(1'b0, 1'b0, 2'd0); step(1'b0, 1'b0, 2'd0);
        step(1'b1, 1'b0, 2'd0);
        check("R6 set wins over clear", int'(irq_raw_o), 1);
        check("R7 irq with mask", int'(irq_o), 1);
        pulse_clear();
        check("R6 clear alone", int'(irq_raw_o), 0);
        check("R7 irq follows raw", int'(irq_o), 0);

        // R8 select change mid-frame and on a boundary cycle
        set_len(2, 2, 2, 2);
        write_cfg(2'd2, 1'b0);
        restart();
        pulse_clear();
        step(1'b0, 1'b0, 2'd0); step(1'b0, 1'b0, 2'd0);       // k=2 back
        check("R8 no evt back with sel 10", int'(irq_evt_o), 0);
        step(1'b0, 1'b1, 2'd1);                                // k=3 write 01 after back passed
        step(1'b0, 1'b0, 2'd0);                                // k=4 active
        check("R8 new code drops active", int'(irq_evt_o), 0);
        for (int k = 5; k <= 9; k++) step(1'b0, 1'b0, 2'd0);
        check("R8 no retroactive fire", int'(irq_raw_o), 0);
        step(1'b0, 1'b0, 2'd0);                                // k=10 back
        check("R8 evt next frame back", int'(irq_evt_o), 1);
        pulse_clear();
        step(1'b0, 1'b0, 2'd0);                                // k=11
        step(1'b0, 1'b1, 2'd2);                                // k=12 active, write same cycle
        check("R8 same-cycle write not used", int'(irq_evt_o), 0);
        check("R8 phase active", int'(phase_o), 2);
        for (int k = 13; k <= 19; k++) step(1'b0, 1'b0, 2'd0);
        check("R8 raw still clear", int'(irq_raw_o), 0);
        step(1'b0, 1'b0, 2'd0);                                // k=20 active
        check("R8 write applied at later boundary", int'(irq_evt_o), 1);

        // R2 R3 R4 R5 R6 R7 sweep over all select codes and length sets, incl. zero length
        for (int s = 0; s < 4; s++) begin
            run_cfg(1, 1, 1, 1, s, s[0]);
            run_cfg(2, 3, 1, 2, s, !s[0]);
            run_cfg(1, 2, 3, 4, s, 1'b1);
            run_cfg(0, 1, 0, 2, s, s[1]);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule